// File: doc/BRIEF.md
# Two-Wire Master Status and Interrupt Vector Unit

This unit keeps the event flags of a host-programmed two-wire bus master, together with the interrupt-enable mask and the two DMA-request enables. From this state it drives one interrupt line, a receive DMA request and a transmit DMA request. The transfer engine and the data buffer raise and drop single flags through per-bit set and clear pulses. The host reaches the unit through a small register port with a select code, a write strobe and a read strobe.

The parameter `NEWER` picks one of two register behaviours. With the older behaviour, the status word is read-only to the host. Pending events are taken one at a time through a vector read: it returns one plus the index of the lowest flag that is both pending and enabled, and it retires that flag. With the newer behaviour, the host retires flags by writing ones to the status word, and the vector read returns zero. The newer behaviour also adds a test write that forces all six event flags high.

The register select codes are 0 for the mask, 1 for status, 2 for the vector, 3 for the DMA config and 4 for the test register. Reads of any other code return zero.

Top module: `twi_status_irq`

## Requirements
- R1: `irq` is high exactly when the stored status AND the enable mask is non-zero.
- R2: `drq_rx` follows status bit 3 only while DMA config bit 15 is set. `drq_tx` follows status bit 4 only while DMA config bit 7 is set. Each request is low while its enable is clear.
- R3: A write with select 3 stores only bits 15 and 7 of the data; reading select 3 returns 0x8080 after writing 0xFFFF. A written bit 15 clears mask bit 3, and a written bit 7 clears mask bit 4.
- R4: Older mode. A read with select 2 returns 1 + index of the lowest set bit of (status AND mask) and clears that status bit. It returns 0, and changes nothing, when no such bit is set.
- R5: Newer mode. A write with select 1 clears those status bits where the data has a one, limited to bits 0, 1, 2 and 5. Older mode. Status writes leave the status unchanged.
- R6: The mask keeps bits 4:0 in older mode and bits 5:0 in newer mode; writing 0xFFFF reads back 0x1F or 0x3F.
- R7: A read with select 1 returns the live `bus_busy` input in bit 12, in addition to the stored flags.
- R8: Newer mode. A write with select 4 and data bit 11 set forces status bits 5:0 to one. Older mode. The same write has no effect.
- R9: A `set_flags` bit sets its status bit. A `clr_flags` bit clears its status bit. When a set and any clear of the same bit fall in one cycle, the set wins.
- R10: `irq`, `drq_rx` and `drq_tx` are registered: they reflect the status and mask of the previous cycle.
- R11: Newer mode. A read with select 2 returns 0 and clears no flag.
- R12: After reset the status, mask, DMA config and all three outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register select code |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe; needed for the vector side effect |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data for the current select (combinational) |
| set_flags | input | 16 | Per-bit set pulses from the engine and buffer |
| clr_flags | input | 16 | Per-bit clear pulses from the engine and buffer |
| bus_busy | input | 1 | Live bus-busy indication |
| irq | output | 1 | Interrupt request |
| drq_rx | output | 1 | Receive DMA request |
| drq_tx | output | 1 | Transmit DMA request |

## Verification
Any wrong status or mask bit shows up on `irq` or on a DMA request one cycle after it is stored. The same wrong bit shows up at once on a status or mask read. A wrong choice of vector index shows in the value returned by that read. It then shows again in the status word on the next cycle, because a flag other than the expected one has been cleared. A wrong priority between a set and a clear leaves the flag low in the cycle after the collision, and a status read shows this directly.

// File: rtl/twi_status_irq.sv
module twi_status_irq #(
  parameter bit NEWER = 1'b1,
  parameter int SW    = 16,
  parameter int EW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [SW-1:0] reg_wdata,
  output logic [SW-1:0] reg_rdata,
  input  logic [SW-1:0] set_flags,
  input  logic [SW-1:0] clr_flags,
  input  logic          bus_busy,
  output logic          irq,
  output logic          drq_rx,
  output logic          drq_tx
);
  localparam logic [2:0]    SEL_MASK = 3'd0, SEL_STAT = 3'd1, SEL_VEC = 3'd2,
                            SEL_DMA = 3'd3, SEL_TEST = 3'd4;
  localparam logic [EW-1:0] KEEP = NEWER ? {EW{1'b1}} : {1'b0, {(EW-1){1'b1}}};
  localparam logic [SW-1:0] W1C  = SW'(16'h0027);
  localparam logic [SW-1:0] BUSY = SW'(1) << 12;
  localparam logic [SW-1:0] DMAK = SW'(16'h8080);
  localparam int            VW   = $clog2(EW + 1);

  logic [SW-1:0] stat, dma;
  logic [EW-1:0] mask, pend, vec_oh;
  logic [VW-1:0] vec_num;

  assign pend = stat[EW-1:0] & mask;

  always_comb begin
    vec_num = '0;
    vec_oh  = '0;
    for (int i = EW - 1; i >= 0; i--)
      if (pend[i]) begin
        vec_num = VW'(i + 1);
        vec_oh  = EW'(1) << i;
      end
  end

  logic wr_stat, wr_test, rd_vec;
  assign wr_stat = reg_wr && reg_sel == SEL_STAT;
  assign wr_test = reg_wr && reg_sel == SEL_TEST && reg_wdata[11];
  assign rd_vec  = reg_rd && reg_sel == SEL_VEC;

  logic [SW-1:0] clr_all, set_all, stat_d;
  assign clr_all = clr_flags
                 | ((NEWER && wr_stat) ? (reg_wdata & W1C) : '0)
                 | ((!NEWER && rd_vec) ? SW'(vec_oh) : '0);
  assign set_all = set_flags | ((NEWER && wr_test) ? SW'({EW{1'b1}}) : '0);
  assign stat_d  = ((stat & ~clr_all) | set_all) & ~BUSY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat   <= '0;
      mask   <= '0;
      dma    <= '0;
      irq    <= 1'b0;
      drq_rx <= 1'b0;
      drq_tx <= 1'b0;
    end else begin
      stat <= stat_d;
      if (reg_wr && reg_sel == SEL_MASK)
        mask <= reg_wdata[EW-1:0] & KEEP;
      else if (reg_wr && reg_sel == SEL_DMA) begin
        dma <= reg_wdata & DMAK;
        if (reg_wdata[15]) mask[3] <= 1'b0;
        if (reg_wdata[7])  mask[4] <= 1'b0;
      end
      irq    <= |pend;
      drq_rx <= dma[15] & stat[3];
      drq_tx <= dma[7]  & stat[4];
    end
  end

  always_comb
    case (reg_sel)
      SEL_MASK: reg_rdata = SW'(mask);
      SEL_STAT: reg_rdata = stat | (bus_busy ? BUSY : '0);
      SEL_VEC:  reg_rdata = NEWER ? '0 : SW'(vec_num);
      SEL_DMA:  reg_rdata = dma;
      default:  reg_rdata = '0;
    endcase
endmodule

module twi_status_irq_chk #(
  parameter bit NEWER = 1'b1,
  parameter int SW    = 16,
  parameter int EW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    reg_sel,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [SW-1:0] reg_wdata,
  input logic [SW-1:0] set_flags,
  input logic [SW-1:0] clr_flags,
  input logic [SW-1:0] stat,
  input logic [EW-1:0] mask
);
  logic [SW-1:0] live_set;
  assign live_set = set_flags & ~(SW'(1) << 12);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    live_set != '0 |=> (stat & $past(live_set)) == $past(live_set));

  a_r5_old_stat_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (!NEWER && reg_wr && reg_sel == 3'd1 && set_flags == '0 && clr_flags == '0)
      |=> stat == $past(stat));

  a_r3_dma_clears_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'd3 && reg_wdata[15]) |=> !mask[3]);

  a_r6_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
    !NEWER |-> !mask[EW-1]);

  a_r4_vec_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!NEWER && reg_rd && !reg_wr && reg_sel == 3'd2 && set_flags == '0 &&
     clr_flags == '0 && (stat[EW-1:0] & mask) != '0)
      |=> $countones(stat[EW-1:0] & mask) == $past($countones(stat[EW-1:0] & mask)) - 1);
endmodule

bind twi_status_irq twi_status_irq_chk #(.NEWER(NEWER), .SW(SW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wdata(reg_wdata), .set_flags(set_flags), .clr_flags(clr_flags),
  .stat(stat), .mask(mask)
);

// File: tb/tb_twi_status_irq.sv
module tb_twi_status_irq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, bus_busy = 1'b0;
  logic [15:0] reg_wdata = '0, set_flags = '0, clr_flags = '0;
  logic [15:0] rd_new, rd_old;
  logic        irq_n, drq_rx_n, drq_tx_n, irq_o, drq_rx_o, drq_tx_o;
  int          total = 0, bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  twi_status_irq #(.NEWER(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(rd_new), .set_flags(set_flags),
    .clr_flags(clr_flags), .bus_busy(bus_busy), .irq(irq_n), .drq_rx(drq_rx_n),
    .drq_tx(drq_tx_n));

  twi_status_irq #(.NEWER(1'b0)) dut_old (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(rd_old), .set_flags(set_flags),
    .clr_flags(clr_flags), .bus_busy(bus_busy), .irq(irq_o), .drq_rx(drq_rx_o),
    .drq_tx(drq_tx_o));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] s, input logic [15:0] c);
    @(negedge clk); set_flags = s; clr_flags = c;
    @(negedge clk); set_flags = '0; clr_flags = '0;
  endtask

  task automatic rd(input logic [2:0] s, input bit strobe, output logic [15:0] vn, output logic [15:0] vo);
    @(negedge clk); reg_sel = s; reg_rd = strobe;
    #1 vn = rd_new; vo = rd_old;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] a, b;
    do_reset();
    chk("R12 irq/drq", {13'b0, irq_n, drq_rx_n, drq_tx_n}, 16'h0);
    rd(3'd1, 1'b0, a, b); chk("R12 status", a, 16'h0);
    rd(3'd0, 1'b0, a, b); chk("R12 mask", a, 16'h0);
    rd(3'd3, 1'b0, a, b); chk("R12 dma", a, 16'h0);
  endtask

  task automatic t_busy();
    logic [15:0] a, b;
    do_reset();
    bus_busy = 1'b1;
    rd(3'd1, 1'b0, a, b); chk("R7 busy bit set", a, 16'h1000);
    bus_busy = 1'b0;
    rd(3'd1, 1'b0, a, b); chk("R7 busy bit clear", a, 16'h0000);
  endtask

  task automatic t_irq();
    do_reset();
    pulse(16'h0004, 16'h0);
    @(negedge clk); chk("R1 masked flag no irq", {15'b0, irq_n}, 16'h0);
    wr(3'd0, 16'h0004);
    chk("R10 irq one cycle late", {15'b0, irq_n}, 16'h0);
    @(negedge clk); chk("R1 irq raised", {15'b0, irq_n}, 16'h1);
    pulse(16'h0, 16'h0004);
    @(negedge clk); chk("R1 irq dropped after clear", {15'b0, irq_n}, 16'h0);
  endtask

  task automatic t_w1c();
    logic [15:0] a, b;
    do_reset();
    pulse(16'h003f, 16'h0);
    wr(3'd1, 16'hffff);
    rd(3'd1, 1'b0, a, b);
    chk("R5 newer w1c limited to 0x27", a, 16'h0018);
    chk("R5 older status write ignored", b, 16'h003f);
  endtask

  task automatic t_mask();
    logic [15:0] a, b;
    do_reset();
    wr(3'd0, 16'hffff);
    rd(3'd0, 1'b0, a, b);
    chk("R6 newer mask width", a, 16'h003f);
    chk("R6 older mask width", b, 16'h001f);
  endtask

  task automatic t_vector();
    logic [15:0] a, b;
    do_reset();
    pulse(16'h002a, 16'h0);
    wr(3'd0, 16'h001f);
    rd(3'd2, 1'b1, a, b);
    chk("R4 vector lowest bit1", b, 16'd2);
    chk("R11 newer vector zero", a, 16'd0);
    rd(3'd1, 1'b0, a, b); chk("R4 bit1 retired", b, 16'h0028);
    rd(3'd2, 1'b1, a, b); chk("R4 vector bit3", b, 16'd4);
    rd(3'd2, 1'b1, a, b); chk("R4 vector none pending", b, 16'd0);
    rd(3'd1, 1'b0, a, b);
    chk("R4 unmasked bit5 kept", b, 16'h0020);
    chk("R11 newer flags untouched", a, 16'h002a);
  endtask

  task automatic t_dma();
    logic [15:0] a, b;
    do_reset();
    wr(3'd0, 16'h003f);
    wr(3'd3, 16'hffff);
    rd(3'd3, 1'b0, a, b); chk("R3 dma stores bits 15,7", a, 16'h8080);
    rd(3'd0, 1'b0, a, b); chk("R3 mask bits 3,4 cleared", a, 16'h0027);
    pulse(16'h0018, 16'h0);
    chk("R10 drq one cycle late", {14'b0, drq_rx_n, drq_tx_n}, 16'h0);
    @(negedge clk);
    chk("R2 both drq", {14'b0, drq_rx_n, drq_tx_n}, 16'h3);
    chk("R1 no irq for unmasked", {15'b0, irq_n}, 16'h0);
    wr(3'd3, 16'h8000);
    @(negedge clk);
    chk("R2 rx only", {14'b0, drq_rx_n, drq_tx_n}, 16'h2);
    wr(3'd3, 16'h0000);
    @(negedge clk);
    chk("R2 none when disabled", {14'b0, drq_rx_n, drq_tx_n}, 16'h0);
  endtask

  task automatic t_test();
    logic [15:0] a, b;
    do_reset();
    wr(3'd4, 16'h0800);
    rd(3'd1, 1'b0, a, b);
    chk("R8 newer force", a, 16'h003f);
    chk("R8 older no force", b, 16'h0000);
  endtask

  task automatic t_priority();
    logic [15:0] a, b;
    do_reset();
    pulse(16'h0001, 16'h0);
    @(negedge clk); reg_sel = 3'd1; reg_wdata = 16'h0001; reg_wr = 1'b1; set_flags = 16'h0001;
    @(negedge clk); reg_wr = 1'b0; set_flags = '0;
    rd(3'd1, 1'b0, a, b); chk("R9 set beats host clear", a, 16'h0001);
    pulse(16'h0001, 16'h0001);
    rd(3'd1, 1'b0, a, b); chk("R9 set beats engine clear", a, 16'h0001);
    pulse(16'h0, 16'h0001);
    rd(3'd1, 1'b0, a, b); chk("R9 engine clear", a, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_busy();
    t_irq();
    t_w1c();
    t_mask();
    t_vector();
    t_dma();
    t_test();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule